// File: doc/BRIEF.md
# PCM Highway Slot Serializer

This block connects a voice codec core to a time-division PCM highway. All of its timing comes from the highway bit clock and a one-bit-wide frame sync pulse. On the transmit side it takes the one or two samples that belong to a frame and shifts them out MSB first on a serial data line. A separate output-enable marks the active bit periods, and the line is released (high-impedance) at all other times. On the receive side it captures the same slot pattern from the serial input and hands the samples out as parallel words, together with a one-clock valid pulse.

Three sample formats are supported: 8-bit mu-law, 8-bit A-law and 16-bit linear. The companding itself is done elsewhere, so this block moves already-encoded bytes. A wide-band option doubles the sample rate to 16 kHz while the frame rate stays at 8 kHz, so each frame then carries two samples. Transmit and receive each have their own start offset, counted in bit clocks from frame sync. The mode and the transmit samples are captured at frame sync and hold for the whole frame.

Top module: `pcm_slot_serdes`

## Requirements
- R1: `fmt` selects the format. 2'b00 is mu-law and 2'b01 is A-law; both carry the low byte of each sample word unchanged (bit 7 sign, bits 6:4 chord, bits 3:0 step) and use identical slot timing. Either 2'b10 or 2'b11 selects 16-bit linear.
- R2: The active region of a frame is a run of back-to-back bits whose length depends on the mode. It is 8 bits for companded, 16 for companded wide-band, 16 for linear and 32 for linear wide-band. In wide-band mode, sample 0 fills the first half and sample 1 the second half.
- R3: Every sample is sent and received MSB first, ending with its LSB.
- R4: Position 0 is the bit period that starts at the rising edge where `fsync` is sampled high. The first transmit bit goes out at position `tx_ofs`. `dtx_oe` is 1 for exactly the active bits, and `dtx` is 0 whenever `dtx_oe` is 0.
- R5: `fmt`, `wide`, both offsets and both transmit samples are taken at the frame-sync edge. Changing them later in the frame does not affect that frame.
- R6: Receive bits are sampled on the falling edge over positions `rx_ofs` onward, using the same slot pattern. A companded sample is zero-extended into `rx_samp0`/`rx_samp1`. `rx_samp1` is 0 when the frame holds one sample.
- R7: `rx_valid` is a one-bit-clock pulse. It rises at the falling edge that captures the last receive bit, and the sample outputs change only together with it.
- R8: A frame sync that arrives before the current frame is finished restarts bit counting at position 0. The cut-off receive frame produces no `rx_valid`.
- R9: From reset until the first frame sync, `dtx_oe` and `rx_valid` stay 0.
- R10: The position counter saturates at its maximum and is not active there. With `OFS_W` of at least 5, the largest offset still fits a full 32-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Highway bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, sampled on the rising edge |
| fmt | input | 2 | Sample format select |
| wide | input | 1 | Two samples per frame (16 kHz) |
| tx_ofs | input | OFS_W | Transmit start offset in bit clocks |
| rx_ofs | input | OFS_W | Receive start offset in bit clocks |
| tx_samp0 | input | 16 | First transmit sample |
| tx_samp1 | input | 16 | Second transmit sample (wide-band) |
| dtx | output | 1 | Serial transmit data |
| dtx_oe | output | 1 | Transmit drive enable; low means released |
| drx | input | 1 | Serial receive data |
| rx_samp0 | output | 16 | First received sample |
| rx_samp1 | output | 16 | Second received sample |
| rx_valid | output | 1 | Received samples updated |

## Verification
The bench builds the block with `OFS_W` = 5, so the position counter saturates at 63 after only a few dozen clocks. At that width the largest offset, 31, can be combined with a 32-bit linear wide-band frame whose last bit lands at position 62, one short of saturation. Every format and wide-band combination is run with transmit and receive offsets that differ. One frame is cut off by an early sync, to show that the counter restarts and no valid pulse appears.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    localparam int SAMP_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * SAMP_W;
    localparam int LEN_W   = 6;

    typedef enum logic [1:0] {
        FMT_ULAW = 2'b00,
        FMT_ALAW = 2'b01,
        FMT_LIN  = 2'b10,
        FMT_LINX = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [1:0] fmt;
        logic       wide;
    } slot_mode_t;

    typedef struct packed {
        logic [SAMP_W-1:0] s0;
        logic [SAMP_W-1:0] s1;
    } samp_pair_t;

    function automatic logic is_linear(input slot_mode_t m);
        return m.fmt[1];
    endfunction

    // Number of active bits in one frame for a mode
    function automatic logic [LEN_W-1:0] slot_len(input slot_mode_t m);
        case ({is_linear(m), m.wide})
            2'b00:   return LEN_W'(BYTE_W);
            2'b01:   return LEN_W'(2 * BYTE_W);
            2'b10:   return LEN_W'(SAMP_W);
            default: return LEN_W'(2 * SAMP_W);
        endcase
    endfunction

    // Left-justified frame word; bit WORD_W-1 leaves first
    function automatic logic [WORD_W-1:0] pack_word(input slot_mode_t m,
                                                    input samp_pair_t p);
        case ({is_linear(m), m.wide})
            2'b00:   return {p.s0[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
            2'b01:   return {p.s0[BYTE_W-1:0], p.s1[BYTE_W-1:0],
                             {(WORD_W-2*BYTE_W){1'b0}}};
            2'b10:   return {p.s0, {SAMP_W{1'b0}}};
            default: return {p.s0, p.s1};
        endcase
    endfunction

    // Right-justified captured bits back into samples
    function automatic samp_pair_t unpack_word(input slot_mode_t m,
                                               input logic [WORD_W-1:0] v);
        samp_pair_t r;
        r = '0;
        case ({is_linear(m), m.wide})
            2'b00: r.s0 = {{(SAMP_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
            2'b01: begin
                r.s0 = {{(SAMP_W-BYTE_W){1'b0}}, v[2*BYTE_W-1:BYTE_W]};
                r.s1 = {{(SAMP_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
            end
            2'b10: r.s0 = v[SAMP_W-1:0];
            default: begin
                r.s0 = v[WORD_W-1:SAMP_W];
                r.s1 = v[SAMP_W-1:0];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_slot_pkg::*;
#(
    parameter int OFS_W = 8,
    localparam int CNT_W = OFS_W + 1
) (
    input  logic             bclk,
    input  logic             rst,
    input  logic             fsync,
    input  slot_mode_t       mode_in,
    input  logic [OFS_W-1:0] tx_ofs_in,
    input  logic [OFS_W-1:0] rx_ofs_in,
    output logic [CNT_W-1:0] pos_q,
    output logic [CNT_W-1:0] pos_nxt,
    output logic             live_q,
    output logic             live_nxt,
    output slot_mode_t       mode_q,
    output slot_mode_t       mode_nxt,
    output logic [OFS_W-1:0] tx_ofs_q,
    output logic [OFS_W-1:0] tx_ofs_nxt,
    output logic [OFS_W-1:0] rx_ofs_q
);

    localparam logic [CNT_W-1:0] POS_MAX = '1;

    always_comb begin
        if (fsync) begin
            pos_nxt    = '0;
            mode_nxt   = mode_in;
            tx_ofs_nxt = tx_ofs_in;
        end else begin
            pos_nxt    = (pos_q == POS_MAX) ? POS_MAX : pos_q + 1'b1;
            mode_nxt   = mode_q;
            tx_ofs_nxt = tx_ofs_q;
        end
        live_nxt = fsync | (live_q & (pos_nxt != POS_MAX));
    end

    always_ff @(posedge bclk) begin
        if (rst) begin
            pos_q    <= POS_MAX;
            live_q   <= 1'b0;
            mode_q   <= '0;
            tx_ofs_q <= '0;
            rx_ofs_q <= '0;
        end else begin
            pos_q    <= pos_nxt;
            live_q   <= live_nxt;
            mode_q   <= mode_nxt;
            tx_ofs_q <= tx_ofs_nxt;
            if (fsync) rx_ofs_q <= rx_ofs_in;
        end
    end

    // R8
    fsync_restart_chk: assert property (@(posedge bclk) disable iff (rst)
        fsync |=> (pos_q == '0 && live_q));

    // R10
    pos_saturate_chk: assert property (@(posedge bclk) disable iff (rst)
        (pos_q == POS_MAX && !fsync) |=> (pos_q == POS_MAX && !live_q));

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
    import pcm_slot_pkg::*;
#(
    parameter int OFS_W = 8,
    localparam int CNT_W = OFS_W + 1
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              fsync,
    input  samp_pair_t        samp_in,
    input  logic [CNT_W-1:0]  pos_q,
    input  logic [CNT_W-1:0]  pos_nxt,
    input  logic              live_q,
    input  logic              live_nxt,
    input  slot_mode_t        mode_nxt,
    input  logic [OFS_W-1:0]  tx_ofs_q,
    input  logic [OFS_W-1:0]  tx_ofs_nxt,
    output logic              dtx,
    output logic              dtx_oe
);

    samp_pair_t        held_q;
    logic [WORD_W-1:0] word_now;
    logic [WORD_W-1:0] word_shift;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  ofs_ext;
    logic              act;

    always_comb begin
        word_now   = pack_word(mode_nxt, fsync ? samp_in : held_q);
        ofs_ext    = CNT_W'(tx_ofs_nxt);
        idx        = pos_nxt - ofs_ext;
        act        = live_nxt && (pos_nxt >= ofs_ext)
                     && (idx < CNT_W'(slot_len(mode_nxt)));
        word_shift = word_now << idx[LEN_W-2:0];
    end

    always_ff @(posedge bclk) begin
        if (rst) begin
            held_q <= '0;
            dtx    <= 1'b0;
            dtx_oe <= 1'b0;
        end else begin
            if (fsync) held_q <= samp_in;
            dtx_oe <= act;
            dtx    <= act & word_shift[WORD_W-1];
        end
    end

    // R4
    idle_low_chk: assert property (@(posedge bclk) disable iff (rst)
        !dtx_oe |-> !dtx);

    // R4
    first_bit_at_ofs_chk: assert property (@(posedge bclk) disable iff (rst)
        $rose(dtx_oe) |-> (pos_q == CNT_W'(tx_ofs_q)));

    // R9
    oe_in_frame_chk: assert property (@(posedge bclk) disable iff (rst)
        dtx_oe |-> live_q);

endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
    import pcm_slot_pkg::*;
#(
    parameter int OFS_W = 8,
    localparam int CNT_W = OFS_W + 1
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              drx,
    input  logic [CNT_W-1:0]  pos_q,
    input  logic              live_q,
    input  slot_mode_t        mode_q,
    input  logic [OFS_W-1:0]  rx_ofs_q,
    output samp_pair_t        samp_out,
    output logic              valid
);

    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] shreg_nxt;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  ofs_ext;
    logic [CNT_W-1:0]  len_ext;
    logic              act;
    logic              last;

    always_comb begin
        ofs_ext   = CNT_W'(rx_ofs_q);
        len_ext   = CNT_W'(slot_len(mode_q));
        idx       = pos_q - ofs_ext;
        act       = live_q && (pos_q >= ofs_ext) && (idx < len_ext);
        last      = act && (idx == len_ext - 1'b1);
        shreg_nxt = {shreg_q[WORD_W-2:0], drx};
    end

    always_ff @(negedge bclk) begin
        if (rst) begin
            shreg_q  <= '0;
            samp_out <= '0;
            valid    <= 1'b0;
        end else begin
            if (act) shreg_q <= shreg_nxt;
            valid <= last;
            if (last) samp_out <= unpack_word(mode_q, shreg_nxt);
        end
    end

    // R7
    valid_pulse_chk: assert property (@(negedge bclk) disable iff (rst)
        valid |=> !valid);

    // R7
    samp_hold_chk: assert property (@(negedge bclk) disable iff (rst)
        !valid |-> $stable(samp_out));

endmodule

// File: rtl/pcm_slot_serdes.sv
module pcm_slot_serdes
    import pcm_slot_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              fsync,
    input  logic [1:0]        fmt,
    input  logic              wide,
    input  logic [OFS_W-1:0]  tx_ofs,
    input  logic [OFS_W-1:0]  rx_ofs,
    input  logic [15:0]       tx_samp0,
    input  logic [15:0]       tx_samp1,
    output logic              dtx,
    output logic              dtx_oe,
    input  logic              drx,
    output logic [15:0]       rx_samp0,
    output logic [15:0]       rx_samp1,
    output logic              rx_valid
);

    localparam int CNT_W = OFS_W + 1;

    slot_mode_t       mode_in, mode_q, mode_nxt;
    samp_pair_t       tx_pair, rx_pair;
    logic [CNT_W-1:0] pos_q, pos_nxt;
    logic             live_q, live_nxt;
    logic [OFS_W-1:0] tx_ofs_q, tx_ofs_nxt, rx_ofs_q;

    assign mode_in  = '{fmt: fmt, wide: wide};
    assign tx_pair  = '{s0: tx_samp0, s1: tx_samp1};
    assign rx_samp0 = rx_pair.s0;
    assign rx_samp1 = rx_pair.s1;

    pcm_frame_timer #(.OFS_W(OFS_W)) u_timer (
        .bclk       (bclk),
        .rst        (rst),
        .fsync      (fsync),
        .mode_in    (mode_in),
        .tx_ofs_in  (tx_ofs),
        .rx_ofs_in  (rx_ofs),
        .pos_q      (pos_q),
        .pos_nxt    (pos_nxt),
        .live_q     (live_q),
        .live_nxt   (live_nxt),
        .mode_q     (mode_q),
        .mode_nxt   (mode_nxt),
        .tx_ofs_q   (tx_ofs_q),
        .tx_ofs_nxt (tx_ofs_nxt),
        .rx_ofs_q   (rx_ofs_q)
    );

    pcm_tx_shifter #(.OFS_W(OFS_W)) u_tx (
        .bclk       (bclk),
        .rst        (rst),
        .fsync      (fsync),
        .samp_in    (tx_pair),
        .pos_q      (pos_q),
        .pos_nxt    (pos_nxt),
        .live_q     (live_q),
        .live_nxt   (live_nxt),
        .mode_nxt   (mode_nxt),
        .tx_ofs_q   (tx_ofs_q),
        .tx_ofs_nxt (tx_ofs_nxt),
        .dtx        (dtx),
        .dtx_oe     (dtx_oe)
    );

    pcm_rx_capture #(.OFS_W(OFS_W)) u_rx (
        .bclk     (bclk),
        .rst      (rst),
        .drx      (drx),
        .pos_q    (pos_q),
        .live_q   (live_q),
        .mode_q   (mode_q),
        .rx_ofs_q (rx_ofs_q),
        .samp_out (rx_pair),
        .valid    (rx_valid)
    );

endmodule

// File: tb/test_pcm_slot_serdes.sv
module test_pcm_slot_serdes;

    localparam int CLK_P = 10;
    localparam int OW    = 5;

    logic          bclk = 1'b0;
    logic          rst  = 1'b1;
    logic          fsync = 1'b0;
    logic [1:0]    fmt = 2'b00;
    logic          wide = 1'b0;
    logic [OW-1:0] tx_ofs = '0;
    logic [OW-1:0] rx_ofs = '0;
    logic [15:0]   tx_samp0 = '0;
    logic [15:0]   tx_samp1 = '0;
    logic          drx = 1'b0;
    logic          dtx, dtx_oe, rx_valid;
    logic [15:0]   rx_samp0, rx_samp1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) bclk = ~bclk;

    pcm_slot_serdes #(.OFS_W(OW)) i_pcm_slot_serdes (
        .bclk(bclk), .rst(rst), .fsync(fsync), .fmt(fmt), .wide(wide),
        .tx_ofs(tx_ofs), .rx_ofs(rx_ofs), .tx_samp0(tx_samp0),
        .tx_samp1(tx_samp1), .dtx(dtx), .dtx_oe(dtx_oe), .drx(drx),
        .rx_samp0(rx_samp0), .rx_samp1(rx_samp1), .rx_valid(rx_valid)
    );

    task automatic step();
        @(posedge bclk);
        #2;
    endtask

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected serial word, left-justified, from the requirements
    function automatic logic [31:0] exp_word(input logic [1:0] f, input logic w,
                                             input logic [15:0] a, input logic [15:0] b);
        if (!f[1]) return w ? {a[7:0], b[7:0], 16'h0} : {a[7:0], 24'h0};
        return w ? {a, b} : {a, 16'h0};
    endfunction

    function automatic int exp_len(input logic [1:0] f, input logic w);
        return (f[1] ? 16 : 8) * (w ? 2 : 1);
    endfunction

    task automatic run_frame(input logic [1:0] f, input logic w,
                             input int to, input int ro,
                             input logic [15:0] a0, input logic [15:0] a1,
                             input logic [15:0] r0, input logic [15:0] r1,
                             input int abort_at, input string name);
        int L, n, vcount, vpos, bad_bits, first_bad;
        logic [31:0] tv, rv;
        logic [15:0] e0, e1;
        L  = exp_len(f, w);
        tv = exp_word(f, w, a0, a1);
        rv = exp_word(f, w, r0, r1);
        fmt = f; wide = w; tx_ofs = OW'(to); rx_ofs = OW'(ro);
        tx_samp0 = a0; tx_samp1 = a1; fsync = 1'b1;
        step();
        fsync = 1'b0;
        // R5: disturb all frame inputs after the sync edge
        tx_samp0 = ~a0; tx_samp1 = ~a1; wide = ~w;
        fmt = {~f[1], f[0]}; tx_ofs = OW'(to + 1); rx_ofs = OW'(ro + 2);
        n = (abort_at > 0) ? abort_at : ((to > ro ? to : ro) + L + 2);
        vcount = 0; vpos = -1; bad_bits = 0; first_bad = -1;
        for (int p = 0; p < n; p++) begin
            bit eoe, ed;
            if (rx_valid) begin vcount++; vpos = p; end
            eoe = (p >= to) && (p < to + L);
            ed  = eoe ? tv[31 - (p - to)] : 1'b0;
            if (dtx_oe !== eoe || dtx !== ed) begin
                bad_bits++;
                if (first_bad < 0) first_bad = p;
            end
            drx = ((p >= ro) && (p < ro + L)) ? rv[31 - (p - ro)] : p[0];
            if (p < n - 1) step();
        end
        // R2 R3 R4 R5: whole transmit stream bit by bit
        check(bad_bits == 0, {"R2/R3/R4/R5 tx stream ", name},
              32'(first_bad), 32'(-1));
        if (abort_at > 0) begin
            // R8: cut-off frame gives no valid
            check(vcount == 0, {"R8 no valid on cut frame ", name},
                  32'(vcount), 32'd0);
        end else begin
            e0 = f[1] ? r0 : {8'h0, r0[7:0]};
            e1 = !w ? 16'h0 : (f[1] ? r1 : {8'h0, r1[7:0]});
            // R7: single pulse one period after the last bit
            check(vcount == 1 && vpos == ro + L, {"R7 valid timing ", name},
                  32'(vpos), 32'(ro + L));
            // R6 R1: captured samples
            check(rx_samp0 === e0, {"R6/R1 rx_samp0 ", name}, 32'(rx_samp0), 32'(e0));
            check(rx_samp1 === e1, {"R6/R1 rx_samp1 ", name}, 32'(rx_samp1), 32'(e1));
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        check(dtx_oe === 1'b0 && dtx === 1'b0, "R9 reset tx idle", {dtx_oe, dtx}, 0);
        check(rx_valid === 1'b0, "R9 reset rx_valid", 32'(rx_valid), 0);
        for (int i = 0; i < 6; i++) begin
            drx = i[0];
            step();
            check(dtx_oe === 1'b0 && rx_valid === 1'b0, "R9 idle before sync",
                  {dtx_oe, rx_valid}, 0);
        end
    endtask

    task automatic test_companded();
        run_frame(2'b00, 1'b0, 0, 0, 16'hxxA5, 16'h0000, 16'h00C3, 16'h0000, 0, "mulaw ofs0");
        run_frame(2'b01, 1'b0, 4, 9, 16'h3C96, 16'hFFFF, 16'hEE5A, 16'h1234, 0, "alaw narrow");
        run_frame(2'b01, 1'b1, 3, 1, 16'h0081, 16'h007E, 16'h00F0, 16'h000F, 0, "alaw wide");
        run_frame(2'b00, 1'b1, 0, 5, 16'h1122, 16'h3344, 16'hAB80, 16'hCD01, 0, "mulaw wide");
    endtask

    task automatic test_linear();
        run_frame(2'b10, 1'b0, 7, 2, 16'h8001, 16'h5555, 16'hC35A, 16'h9999, 0, "lin narrow");
        run_frame(2'b11, 1'b1, 1, 6, 16'hDEAD, 16'hBEEF, 16'h1357, 16'h2468, 0, "lin wide fmt3");
        // R10: largest offset with the longest frame
        run_frame(2'b10, 1'b1, 31, 31, 16'hF00F, 16'h0FF0, 16'hA5A5, 16'h5A5A, 0, "R10 max offset");
    endtask

    task automatic test_early_sync();
        run_frame(2'b10, 1'b1, 2, 2, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 10, "R8 cut");
        run_frame(2'b00, 1'b0, 0, 1, 16'h006B, 16'h0000, 16'h0097, 16'h0000, 0, "R8 after restart");
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_companded();
        test_linear();
        test_early_sync();
        repeat (4) step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule